// File: doc/BRIEF.md
# Operand-Location Cluster Steering Unit

This unit picks an execution cluster for every instruction of a rename group on a machine with four clusters. Cluster `c` writes its results only into register subset `c`, so the chosen cluster is also the subset that the renamer must allocate the destination from. Each cluster reads its first operand from one fixed pair of subsets and its second operand from another fixed pair. The cluster number is therefore mostly dictated by where the sources currently live.

The unit keeps two one-bit-per-logical-register vectors, a high vector and a low vector. Together they give the 2-bit subset number that holds each logical register. For each slot, the high bit of the cluster comes from the first operand's location and the low bit from the second operand's location. An earlier slot in the same group that writes a source register overrides the vectors for the later slot. Any bit that no operand fixes is drawn from a 16-bit LFSR. In swap mode, eligible instructions may also have their operand order reversed at random.

At the clock edge that accepts a group, the vectors record the cluster of every destination written, and the LFSR moves forward. The per-slot cluster outputs form the subset target vector handed to the renamer.

Top module: `steer_unit`

## Requirements
- R1: After reset, logical register `i` lives in subset `i mod 4`. A slot whose two operands are both register `i` is steered to cluster `i mod 4`.
- R2: For a slot with both operands and no swap, cluster bit 1 equals bit 1 of the first operand's subset, and cluster bit 0 equals bit 0 of the second operand's subset.
- R3: For a slot with only the first operand and no swap, cluster bit 1 comes from that operand's subset and cluster bit 0 is bit 0 of the slot's random word. For a slot with only the second operand, bit 0 comes from the operand and bit 1 is bit 1 of the random word.
- R4: A slot with no register operand gets cluster = {random bit 1, random bit 0}.
- R5: When an earlier valid slot of the same group writes a register that a later slot reads, the later slot uses that earlier slot's cluster as the operand's subset. The latest such earlier slot wins.
- R6: When a group is accepted, each valid slot with a destination moves its destination register into the subset equal to its cluster. A later slot wins on the same register. Slots without a destination change nothing.
- R7: With swap mode on, a commutative two-operand slot swaps when random bit 2 is 1. A swapped slot gets cluster {bit 1 of second-operand subset, bit 0 of first-operand subset}. Non-commutative two-operand slots and operand-free slots never swap. `swapOut` reports the swap.
- R8: With swap mode on, a one-operand slot swaps when random bit 2 is 1. Swapping moves the operand to the other entry, so it fixes the other cluster bit, and the free bit comes from the random word as in R3.
- R9: The LFSR is 16 bits wide, seeded to 0xACE1 at reset, and steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. Slot `j` uses the state stepped `j` times from the current one. An accepted group steps the register GROUP times; otherwise it holds.
- R10: When `groupValid` is low, or a slot's valid bit is low, that slot's `clusterOut` and `swapOut` are 0 and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| groupValid | input | 1 | A group is presented and accepted this cycle |
| swapEn | input | 1 | Random operand-order mode |
| slotValid | input | GROUP | Per-slot instruction valid |
| src1Valid | input | GROUP | Slot has a first register operand |
| src1Idx | input | GROUP*IDX_W | First operand logical register, slot j at [j*IDX_W +: IDX_W] |
| src2Valid | input | GROUP | Slot has a second register operand |
| src2Idx | input | GROUP*IDX_W | Second operand logical register |
| dstValid | input | GROUP | Slot writes a register |
| dstIdx | input | GROUP*IDX_W | Destination logical register |
| commutative | input | GROUP | Two-operand slot may have its operands swapped |
| clusterOut | output | GROUP*2 | Chosen cluster (and destination subset), slot j at [2j +: 2] |
| swapOut | output | GROUP | Slot's operand order was reversed |

## Verification
The bench targets in-group chains, where a later slot reads a register written earlier in the same group. A unit that ignored them would steer by the stale vector value. It also covers two slots writing the same register, where the wrong winner leaves a register in the wrong subset for every later group. Swap-mode groups mix commutative, non-commutative and operand-free slots. A unit that swapped the wrong class, or took the bits from the wrong entry after a swap, gives a different cluster than the model. Idle cycles between groups check that the random sequence does not drift.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int SUBSET_W = 2;
  localparam int RND_W    = 16;
  localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;

  typedef logic [SUBSET_W-1:0] subset_t;

  // Per-slot write strobe handed from control to datapath
  typedef struct packed {
    logic    we;
    subset_t subset;
  } slotWr_t;

  function automatic logic [RND_W-1:0] rndStep(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/steer_location_dp.sv
module steer_location_dp
  import steer_pkg::*;
#(
  parameter int NUM_LREGS = 32,
  parameter int GROUP     = 4,
  parameter int IDX_W     = $clog2(NUM_LREGS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [GROUP*IDX_W-1:0] src1Idx,
  input  logic [GROUP*IDX_W-1:0] src2Idx,
  input  logic [GROUP*IDX_W-1:0] dstIdx,
  input  slotWr_t                wrStrobe [GROUP],
  output subset_t                rawSub1  [GROUP],
  output subset_t                rawSub2  [GROUP]
);

  logic [NUM_LREGS-1:0] hiVec;
  logic [NUM_LREGS-1:0] loVec;

  // Read ports: one pair per slot, straight from the stored vectors
  for (genvar j = 0; j < GROUP; j++) begin : g_read
    logic [IDX_W-1:0] a1;
    logic [IDX_W-1:0] a2;
    assign a1 = src1Idx[j*IDX_W +: IDX_W];
    assign a2 = src2Idx[j*IDX_W +: IDX_W];
    assign rawSub1[j] = {hiVec[a1], loVec[a1]};
    assign rawSub2[j] = {hiVec[a2], loVec[a2]};
  end

  // Update: ascending slot order so the youngest writer lands last
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LREGS; i++) begin
        hiVec[i] <= 1'(i >> 1);
        loVec[i] <= 1'(i);
      end
    end else begin
      for (int j = 0; j < GROUP; j++) begin
        if (wrStrobe[j].we) begin
          hiVec[dstIdx[j*IDX_W +: IDX_W]] <= wrStrobe[j].subset[1];
          loVec[dstIdx[j*IDX_W +: IDX_W]] <= wrStrobe[j].subset[0];
        end
      end
    end
  end

endmodule

// File: rtl/steer_decide_ctl.sv
module steer_decide_ctl
  import steer_pkg::*;
#(
  parameter int GROUP = 4,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   groupValid,
  input  logic                   swapEn,
  input  logic [GROUP-1:0]       slotValid,
  input  logic [GROUP-1:0]       src1Valid,
  input  logic [GROUP*IDX_W-1:0] src1Idx,
  input  logic [GROUP-1:0]       src2Valid,
  input  logic [GROUP*IDX_W-1:0] src2Idx,
  input  logic [GROUP-1:0]       dstValid,
  input  logic [GROUP*IDX_W-1:0] dstIdx,
  input  logic [GROUP-1:0]       commutative,
  input  subset_t                rawSub1 [GROUP],
  input  subset_t                rawSub2 [GROUP],
  output subset_t                clus    [GROUP],
  output logic [GROUP-1:0]       swp,
  output slotWr_t                wrStrobe [GROUP]
);

  logic [RND_W-1:0] rndQ;
  logic [RND_W-1:0] rnd [GROUP+1];

  assign rnd[0] = rndQ;
  for (genvar j = 0; j < GROUP; j++) begin : g_rnd
    assign rnd[j+1] = rndStep(rnd[j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rndQ <= RND_SEED;
    else if (groupValid) rndQ <= rnd[GROUP];
  end

  always_comb begin
    subset_t s1;
    subset_t s2;
    subset_t e1s;
    subset_t e2s;
    logic    e1v;
    logic    e2v;
    logic    canSwap;
    logic    sw;
    logic    act;
    for (int j = 0; j < GROUP; j++) begin
      s1 = rawSub1[j];
      s2 = rawSub2[j];
      // Pseudo-dependency forwarding from older slots of this group
      for (int k = 0; k < j; k++) begin
        if (wrStrobe[k].we && dstIdx[k*IDX_W +: IDX_W] == src1Idx[j*IDX_W +: IDX_W])
          s1 = clus[k];
        if (wrStrobe[k].we && dstIdx[k*IDX_W +: IDX_W] == src2Idx[j*IDX_W +: IDX_W])
          s2 = clus[k];
      end
      act     = groupValid & slotValid[j];
      canSwap = swapEn & (src1Valid[j] | src2Valid[j])
              & (commutative[j] | ~(src1Valid[j] & src2Valid[j]));
      sw      = canSwap & rnd[j][2];
      e1v     = sw ? src2Valid[j] : src1Valid[j];
      e2v     = sw ? src1Valid[j] : src2Valid[j];
      e1s     = sw ? s2 : s1;
      e2s     = sw ? s1 : s2;
      if (act) begin
        clus[j] = {e1v ? e1s[1] : rnd[j][1], e2v ? e2s[0] : rnd[j][0]};
        swp[j]  = sw;
      end else begin
        clus[j] = '0;
        swp[j]  = 1'b0;
      end
      wrStrobe[j].we     = act & dstValid[j];
      wrStrobe[j].subset = clus[j];
    end
  end

endmodule

// File: rtl/steer_unit.sv
module steer_unit
  import steer_pkg::*;
#(
  parameter int NUM_LREGS = 32,
  parameter int GROUP     = 4,
  parameter int IDX_W     = $clog2(NUM_LREGS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   groupValid,
  input  logic                   swapEn,
  input  logic [GROUP-1:0]       slotValid,
  input  logic [GROUP-1:0]       src1Valid,
  input  logic [GROUP*IDX_W-1:0] src1Idx,
  input  logic [GROUP-1:0]       src2Valid,
  input  logic [GROUP*IDX_W-1:0] src2Idx,
  input  logic [GROUP-1:0]       dstValid,
  input  logic [GROUP*IDX_W-1:0] dstIdx,
  input  logic [GROUP-1:0]       commutative,
  output logic [GROUP*2-1:0]     clusterOut,
  output logic [GROUP-1:0]       swapOut
);

  subset_t rawSub1  [GROUP];
  subset_t rawSub2  [GROUP];
  subset_t clus     [GROUP];
  slotWr_t wrStrobe [GROUP];

  steer_location_dp #(.NUM_LREGS(NUM_LREGS), .GROUP(GROUP), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .src1Idx(src1Idx), .src2Idx(src2Idx), .dstIdx(dstIdx),
    .wrStrobe(wrStrobe), .rawSub1(rawSub1), .rawSub2(rawSub2)
  );

  steer_decide_ctl #(.GROUP(GROUP), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .groupValid(groupValid), .swapEn(swapEn),
    .slotValid(slotValid), .src1Valid(src1Valid), .src1Idx(src1Idx),
    .src2Valid(src2Valid), .src2Idx(src2Idx), .dstValid(dstValid),
    .dstIdx(dstIdx), .commutative(commutative),
    .rawSub1(rawSub1), .rawSub2(rawSub2),
    .clus(clus), .swp(swapOut), .wrStrobe(wrStrobe)
  );

  for (genvar j = 0; j < GROUP; j++) begin : g_out
    assign clusterOut[j*2 +: 2] = clus[j];
  end

endmodule

// File: rtl/steer_unit_chk.sv
module steer_unit_chk #(
  parameter int GROUP = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             groupValid,
  input logic             swapEn,
  input logic [GROUP-1:0] slotValid,
  input logic [GROUP-1:0] src1Valid,
  input logic [GROUP-1:0] src2Valid,
  input logic [GROUP-1:0] commutative,
  input logic [GROUP*2-1:0] clusterOut,
  input logic [GROUP-1:0] swapOut
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !groupValid |-> (clusterOut == '0 && swapOut == '0));

  p_swap_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    !swapEn |-> swapOut == '0);

  for (genvar j = 0; j < GROUP; j++) begin : g_slot
    p_noncomm_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
      (src1Valid[j] && src2Valid[j] && !commutative[j]) |-> !swapOut[j]);

    p_no_operand_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!src1Valid[j] && !src2Valid[j]) |-> !swapOut[j]);

    p_dead_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
      !slotValid[j] |-> (clusterOut[j*2 +: 2] == 2'b00 && !swapOut[j]));
  end

endmodule

bind steer_unit steer_unit_chk #(.GROUP(GROUP)) u_chk (
  .clk(clk), .rstN(rstN), .groupValid(groupValid), .swapEn(swapEn),
  .slotValid(slotValid), .src1Valid(src1Valid), .src2Valid(src2Valid),
  .commutative(commutative), .clusterOut(clusterOut), .swapOut(swapOut)
);

// File: tb/steer_unit_tb.sv
`timescale 1ns/1ps
module steer_unit_tb;
  localparam int G  = 4;
  localparam int N  = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, groupValid, swapEn;
  logic [G-1:0] slotValid, src1Valid, src2Valid, dstValid, commutative;
  logic [G*IW-1:0] src1Idx, src2Idx, dstIdx;
  logic [G*2-1:0] clusterOut;
  logic [G-1:0] swapOut;

  // staging copies driven on the falling edge
  logic sGv, sSw;
  logic [G-1:0] sSlv, sS1v, sS2v, sDv, sCom;
  logic [G*IW-1:0] sS1, sS2, sD;

  steer_unit u_dut (
    .clk(clk), .rstN(rstN), .groupValid(groupValid), .swapEn(swapEn),
    .slotValid(slotValid), .src1Valid(src1Valid), .src1Idx(src1Idx),
    .src2Valid(src2Valid), .src2Idx(src2Idx), .dstValid(dstValid),
    .dstIdx(dstIdx), .commutative(commutative),
    .clusterOut(clusterOut), .swapOut(swapOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] mRnd;
  logic [N-1:0] mHi, mLo;

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clearStage();
    sGv = 0; sSw = 0; sSlv = '0; sS1v = '0; sS2v = '0; sDv = '0; sCom = '0;
    sS1 = '0; sS2 = '0; sD = '0;
  endtask

  // apply staged group, compare with the model, then advance the model
  task automatic runGroup(input string tag);
    logic [15:0] r [G+1];
    logic [1:0] expC [G];
    logic [1:0] a, b, e1s, e2s;
    logic act, can, sw, e1v, e2v, fwd;
    string req;
    @(negedge clk);
    groupValid = sGv; swapEn = sSw; slotValid = sSlv; src1Valid = sS1v;
    src2Valid = sS2v; dstValid = sDv; commutative = sCom;
    src1Idx = sS1; src2Idx = sS2; dstIdx = sD;
    #1;
    r[0] = mRnd;
    for (int j = 0; j < G; j++) r[j+1] = nxt(r[j]);
    for (int j = 0; j < G; j++) begin
      a = {mHi[sS1[j*IW +: IW]], mLo[sS1[j*IW +: IW]]};
      b = {mHi[sS2[j*IW +: IW]], mLo[sS2[j*IW +: IW]]};
      fwd = 0;
      for (int k = 0; k < j; k++) begin
        if (sGv && sSlv[k] && sDv[k] && sD[k*IW +: IW] == sS1[j*IW +: IW]) begin a = expC[k]; fwd = sS1v[j]; end
        if (sGv && sSlv[k] && sDv[k] && sD[k*IW +: IW] == sS2[j*IW +: IW]) begin b = expC[k]; fwd = fwd | sS2v[j]; end
      end
      act = sGv & sSlv[j];
      can = sSw & (sS1v[j] | sS2v[j]) & (sCom[j] | ~(sS1v[j] & sS2v[j]));
      sw  = act & can & r[j][2];
      e1v = sw ? sS2v[j] : sS1v[j];
      e2v = sw ? sS1v[j] : sS2v[j];
      e1s = sw ? b : a;
      e2s = sw ? a : b;
      expC[j] = act ? {e1v ? e1s[1] : r[j][1], e2v ? e2s[0] : r[j][0]} : 2'b00;
      if (tag != "") req = tag;
      else if (!act) req = "R10";
      else if (sw) req = (sS1v[j] & sS2v[j]) ? "R7" : "R8";
      else if (fwd) req = "R5";
      else if (sS1v[j] & sS2v[j]) req = "R2";
      else if (sS1v[j] | sS2v[j]) req = sSw ? "R8" : "R3";
      else req = "R4";
      check({req, " cluster"}, {6'd0, clusterOut[j*2 +: 2]}, {6'd0, expC[j]});
      check({req, " swap"}, {7'd0, swapOut[j]}, {7'd0, sw});
    end
    for (int j = 0; j < G; j++)
      if (sGv && sSlv[j] && sDv[j]) begin
        mHi[sD[j*IW +: IW]] = expC[j][1];
        mLo[sD[j*IW +: IW]] = expC[j][0];
      end
    if (sGv) mRnd = r[G];
  endtask

  // read register x in a single dyadic slot (no write)
  task automatic probe(input int x, input string tag);
    clearStage();
    sGv = 1; sSlv[0] = 1; sS1v[0] = 1; sS2v[0] = 1;
    sS1[0 +: IW] = IW'(x); sS2[0 +: IW] = IW'(x);
    runGroup(tag);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rstN = 0; groupValid = 0; swapEn = 0; slotValid = '0; src1Valid = '0;
    src2Valid = '0; dstValid = '0; commutative = '0;
    src1Idx = '0; src2Idx = '0; dstIdx = '0;
    clearStage();
    mRnd = 16'hACE1;
    for (int i = 0; i < N; i++) begin mHi[i] = 1'(i >> 1); mLo[i] = 1'(i); end
    repeat (3) @(posedge clk);
    rstN = 1;

    // R10: idle cycle right after reset outputs zero
    clearStage(); sSlv = '1; sS1v = '1; sDv = '1;
    runGroup("R10");

    // R1: initial spread, every register probed
    for (int i = 0; i < N; i++) probe(i, "R1");

    // R9: noadic slots after several idle cycles follow the LFSR sequence
    clearStage(); runGroup("R9"); runGroup("R9");
    clearStage(); sGv = 1; sSlv = '1; runGroup("R9");

    // R5: slot0 writes r5 (noadic), slot1 reads r5 as both operands
    clearStage(); sGv = 1; sSlv = 4'b0011;
    sDv[0] = 1; sD[0 +: IW] = 5'd5;
    sS1v[1] = 1; sS2v[1] = 1; sS1[IW +: IW] = 5'd5; sS2[IW +: IW] = 5'd5;
    runGroup("R5");
    probe(5, "R6");

    // R6: two writers of r7, later one wins; r8 untouched by a dst-less slot
    clearStage(); sGv = 1; sSlv = '1;
    sDv[0] = 1; sD[0 +: IW] = 5'd7;
    sDv[2] = 1; sD[2*IW +: IW] = 5'd7;
    sS1v[3] = 1; sS1[3*IW +: IW] = 5'd8;
    runGroup("R6");
    probe(7, "R6");
    probe(8, "R6");

    // R10: invalid slots with groupValid high change nothing
    clearStage(); sGv = 1; sSlv = '0; sDv = '1; sD = {5'd8, 5'd8, 5'd8, 5'd8};
    runGroup("R10");
    probe(8, "R10");

    // R3 / R8 / R7 directed one-operand and commutative groups
    clearStage(); sGv = 1; sSlv = '1; sS1v = 4'b0101; sS2v = 4'b1010;
    sS1 = {5'd3, 5'd2, 5'd1, 5'd0}; sS2 = {5'd6, 5'd9, 5'd12, 5'd15};
    runGroup("R3");
    sSw = 1; runGroup("R8"); runGroup("R8");
    clearStage(); sGv = 1; sSw = 1; sSlv = '1; sS1v = '1; sS2v = '1; sCom = 4'b1100;
    sS1 = {5'd1, 5'd2, 5'd3, 5'd4}; sS2 = {5'd6, 5'd7, 5'd8, 5'd9};
    runGroup("R7"); runGroup("R7"); runGroup("R7");

    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      sGv  = ($urandom_range(0, 9) != 0);
      sSw  = $urandom_range(0, 1);
      sSlv = G'($urandom); sS1v = G'($urandom); sS2v = G'($urandom);
      sDv  = G'($urandom); sCom = G'($urandom);
      // narrow register range so in-group hazards are frequent
      for (int j = 0; j < G; j++) begin
        sS1[j*IW +: IW] = IW'($urandom_range(0, 7));
        sS2[j*IW +: IW] = IW'($urandom_range(0, 7));
        sD[j*IW +: IW]  = IW'($urandom_range(0, 7));
      end
      runGroup("");
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule